// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block holds the status and control word that sits beside a floating-point datapath. Each time the datapath finishes an operation it pulses a completion strobe and reports which exceptions that operation raised: inexact, underflow, divide-by-zero, overflow, invalid and unimplemented, plus a separate flag for a denormal source operand. The block qualifies these events against the exception enables and the denormal-flush control. It raises an exception-trap request in the same cycle as the strobe and updates its per-operation cause bits and its accumulated sticky flags.

Software reads the whole word and writes it with per-field rules. Sticky flags, enables, the flush control and the rounding mode are written directly. Cause bits can only be cleared, by writing 0. The summary bit cannot be written and always shows the OR of the underflow, divide-by-zero, overflow and invalid sticky flags. The rounding mode and flush control are driven out to the datapath.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset the word reads 0x0000_0100: flush control set, every other field 0, rounding mode output 00 and trap request low.
- R2: The word uses MSB-first positions in which bit 31 of the vector is position 0. Vector bit 31 is the summary, bits 30..26 are the sticky flags {inexact, underflow, div-by-zero, overflow, invalid}, bits 14..10 are the enables in the same order, bit 8 is flush, bit 7 is the unimplemented cause, bits 6..2 are the causes in the same order and bits 1..0 are the rounding mode. All other bits read 0. The summary reads the OR of the underflow, div-by-zero, overflow and invalid flags, and the inexact flag does not feed it.
- R3: When an operation completes without a trap, every exception it raised sets its sticky flag, and a flag stays at 1 until software writes it to 0.
- R4: When an operation completes with a trap, no sticky flag changes. This includes two simultaneous exceptions with one enabled and one masked.
- R5: Every completed operation replaces all cause bits with exactly the exceptions of that operation, so causes from earlier operations are cleared.
- R6: A software write of 0 to a cause bit clears it, and a write of 1 leaves it unchanged.
- R7: Software writes load the sticky flags, enables, flush control and rounding mode directly. Writes to the summary bit and to reserved bits have no effect.
- R8: The trap request is high only in a cycle with the completion strobe, and then only when a raised exception has its enable set or an unimplemented exception is present. Exception inputs without the strobe do nothing.
- R9: An unimplemented exception always requests a trap, whatever the enables are, and sets the unimplemented cause.
- R10: With flush at 0, a denormal operand or an underflow result produces an unimplemented exception. With flush at 1, a denormal operand raises nothing.
- R11: An overflow whose enable is clear also raises inexact in the same operation, for causes, flags and trap enabling. An enabled overflow does not add inexact.
- R12: The rounding mode output follows the field: 00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity. The flush output follows the flush bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done_i | input | 1 | Floating-point operation completed this cycle |
| exc_i | input | 5 | Raised exceptions {inexact, underflow, div-by-zero, overflow, invalid} |
| unimpl_i | input | 1 | Unimplemented-operation exception raised |
| denorm_op_i | input | 1 | A source operand was denormal |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Current register word |
| eit_req_o | output | 1 | Exception trap request |
| round_mode_o | output | 2 | Current rounding mode |
| flush_denorm_o | output | 1 | Denormals treated as zero |

## Verification
The trap request is combinational from the strobe and the held enables, so the bench samples it a few nanoseconds after driving the strobe at a falling edge and before the next rising edge. Flags, causes and control fields take effect at the rising edge that captures the strobe or write. The bench therefore reads the word and the mode outputs at the following falling edge, one cycle after the stimulus, with the inputs already withdrawn.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  // number of maskable exception kinds
  localparam int NUM_EXC  = 5;
  // index of each kind inside an exception vector
  localparam int IDX_INV  = 0;
  localparam int IDX_OVF  = 1;
  localparam int IDX_DZ   = 2;
  localparam int IDX_UDF  = 3;
  localparam int IDX_INX  = 4;
  // field placement inside the 32-bit word (vector bit numbers)
  localparam int WORD_W   = 32;
  localparam int SUM_BIT  = 31;
  localparam int FLAG_LSB = 26;
  localparam int EN_LSB   = 10;
  localparam int DN_BIT   = 8;
  localparam int CE_BIT   = 7;
  localparam int CAUSE_LSB= 2;
  localparam int RM_W     = 2;
  localparam int RM_LSB   = 0;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0100;
endpackage

// File: rtl/fpsr_event_qual.sv
module fpsr_event_qual
  import fpsr_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         op_done_i,
  input  logic [N-1:0] exc_raw_i,
  input  logic         unimpl_raw_i,
  input  logic         denorm_op_i,
  input  logic [N-1:0] enable_i,
  input  logic         flush_i,
  output logic [N-1:0] exc_eff_o,
  output logic         unimpl_eff_o,
  output logic         eit_o
);
  logic         ovf_masked;
  logic [N-1:0] exc_ext;
  logic [N-1:0] hit_enabled;

  // a masked overflow drags inexact along with it
  assign ovf_masked = exc_raw_i[IDX_OVF] & ~enable_i[IDX_OVF];

  always_comb begin
    exc_ext = exc_raw_i;
    exc_ext[IDX_INX] = exc_raw_i[IDX_INX] | ovf_masked;
  end

  assign exc_eff_o = op_done_i ? exc_ext : '0;

  // without flush, denormal inputs or tiny results cannot be handled
  assign unimpl_eff_o = op_done_i &
                        (unimpl_raw_i |
                         (denorm_op_i & ~flush_i) |
                         (exc_raw_i[IDX_UDF] & ~flush_i));

  assign hit_enabled = exc_eff_o & enable_i;
  assign eit_o       = unimpl_eff_o | (|hit_enabled);
endmodule

// File: rtl/fpsr_sticky.sv
module fpsr_sticky
  import fpsr_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_done_i,
  input  logic         eit_i,
  input  logic [N-1:0] exc_eff_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_flags_i,
  output logic [N-1:0] flags_o
);
  logic update_ok;
  assign update_ok = op_done_i & ~eit_i;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags_o[i] <= 1'b0;
      else if (update_ok && exc_eff_i[i])
        flags_o[i] <= 1'b1;
      else if (wr_en_i)
        flags_o[i] <= wr_flags_i[i];
    end
  end

  // R3: exceptions of an untrapped operation show up as flags
  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    (op_done_i && !eit_i) |=> ((flags_o & $past(exc_eff_i)) == $past(exc_eff_i)));

  // R4: a trapped operation leaves the flags alone
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (op_done_i && eit_i && !wr_en_i) |=> (flags_o == $past(flags_o)));
endmodule

// File: rtl/fpsr_cause.sv
module fpsr_cause
  import fpsr_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_done_i,
  input  logic [N-1:0] exc_eff_i,
  input  logic         unimpl_eff_i,
  input  logic         wr_en_i,
  input  logic [N:0]   wr_cause_i,
  output logic [N:0]   cause_o
);
  logic [N:0] fresh;
  assign fresh = {unimpl_eff_i, exc_eff_i};

  for (genvar i = 0; i <= N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst)
        cause_o[i] <= 1'b0;
      else if (op_done_i)
        cause_o[i] <= fresh[i];
      else if (wr_en_i && !wr_cause_i[i])
        cause_o[i] <= 1'b0;
    end
  end

  // R5: each completed operation replaces the cause set
  p_cause_replace_r5: assert property (@(posedge clk) disable iff (rst)
    op_done_i |=> (cause_o == $past(fresh)));

  // R6: outside operations, cause bits may only fall
  p_cause_no_rise_r6: assert property (@(posedge clk) disable iff (rst)
    !op_done_i |=> ((cause_o & ~$past(cause_o)) == '0));
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_done_i,
  input  logic [N-1:0]      exc_i,
  input  logic              unimpl_i,
  input  logic              denorm_op_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              eit_req_o,
  output logic [RM_W-1:0]   round_mode_o,
  output logic              flush_denorm_o
);
  logic [N-1:0]    enable_q;
  logic            flush_q;
  logic [RM_W-1:0] rm_q;
  logic [N-1:0]    exc_eff;
  logic            unimpl_eff;
  logic [N-1:0]    flags;
  logic [N:0]      cause;
  logic            unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[SUM_BIT], wr_data_i[FLAG_LSB-1:EN_LSB+N],
                            wr_data_i[DN_BIT+1]};

  fpsr_event_qual #(.N(N)) i_qual (
    .op_done_i    (op_done_i),
    .exc_raw_i    (exc_i),
    .unimpl_raw_i (unimpl_i),
    .denorm_op_i  (denorm_op_i),
    .enable_i     (enable_q),
    .flush_i      (flush_q),
    .exc_eff_o    (exc_eff),
    .unimpl_eff_o (unimpl_eff),
    .eit_o        (eit_req_o)
  );

  fpsr_sticky #(.N(N)) i_sticky (
    .clk        (clk),
    .rst        (rst),
    .op_done_i  (op_done_i),
    .eit_i      (eit_req_o),
    .exc_eff_i  (exc_eff),
    .wr_en_i    (wr_en_i),
    .wr_flags_i (wr_data_i[FLAG_LSB+N-1:FLAG_LSB]),
    .flags_o    (flags)
  );

  fpsr_cause #(.N(N)) i_cause (
    .clk          (clk),
    .rst          (rst),
    .op_done_i    (op_done_i),
    .exc_eff_i    (exc_eff),
    .unimpl_eff_i (unimpl_eff),
    .wr_en_i      (wr_en_i),
    .wr_cause_i   (wr_data_i[CAUSE_LSB+N:CAUSE_LSB]),
    .cause_o      (cause)
  );

  // software-owned control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      flush_q  <= RESET_WORD[DN_BIT];
      rm_q     <= RESET_WORD[RM_LSB+RM_W-1:RM_LSB];
    end else if (wr_en_i) begin
      enable_q <= wr_data_i[EN_LSB+N-1:EN_LSB];
      flush_q  <= wr_data_i[DN_BIT];
      rm_q     <= wr_data_i[RM_LSB+RM_W-1:RM_LSB];
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[SUM_BIT] = flags[IDX_UDF] | flags[IDX_DZ] |
                         flags[IDX_OVF] | flags[IDX_INV];
    rd_data_o[FLAG_LSB+N-1:FLAG_LSB]   = flags;
    rd_data_o[EN_LSB+N-1:EN_LSB]       = enable_q;
    rd_data_o[DN_BIT]                  = flush_q;
    rd_data_o[CAUSE_LSB+N:CAUSE_LSB]   = cause;
    rd_data_o[RM_LSB+RM_W-1:RM_LSB]    = rm_q;
  end

  assign round_mode_o   = rm_q;
  assign flush_denorm_o = flush_q;

  // R8: no trap request without a completed operation
  p_eit_needs_op_r8: assert property (@(posedge clk) disable iff (rst)
    !op_done_i |-> !eit_req_o);

  // R9: unimplemented operations always trap
  p_unimpl_traps_r9: assert property (@(posedge clk) disable iff (rst)
    (op_done_i && unimpl_i) |-> eit_req_o);

  // R12: a write lands in the rounding-mode output next cycle
  p_rm_follows_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (round_mode_o == $past(wr_data_i[RM_LSB+RM_W-1:RM_LSB])));

  // R7: flush output tracks written data
  p_flush_follows_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (flush_denorm_o == $past(wr_data_i[DN_BIT])));
endmodule

// File: tb/test_fpsr_ctrl.sv
module test_fpsr_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_done_i;
  logic [4:0]  exc_i;
  logic        unimpl_i;
  logic        denorm_op_i;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        eit_req_o;
  logic [1:0]  round_mode_o;
  logic        flush_denorm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic eit_seen;

  always #10 clk = ~clk;

  fpsr_ctrl i_fpsr_ctrl (
    .clk(clk), .rst(rst), .op_done_i(op_done_i), .exc_i(exc_i),
    .unimpl_i(unimpl_i), .denorm_op_i(denorm_op_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .eit_req_o(eit_req_o),
    .round_mode_o(round_mode_o), .flush_denorm_o(flush_denorm_o)
  );

  // exception vector order {inexact, underflow, div-zero, overflow, invalid}
  localparam logic [4:0] E_X = 5'b10000, E_U = 5'b01000, E_Z = 5'b00100,
                         E_O = 5'b00010, E_V = 5'b00001;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive an operation at a falling edge; trap sampled before the rising edge
  task automatic do_op(input logic [4:0] e, input logic u, input logic d);
    op_done_i = 1'b1; exc_i = e; unimpl_i = u; denorm_op_i = d;
    #3 eit_seen = eit_req_o;
    @(negedge clk);
    op_done_i = 1'b0; exc_i = '0; unimpl_i = 1'b0; denorm_op_i = 1'b0;
  endtask

  task automatic sw_write(input logic [31:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 word", rd_data_o, 32'h0000_0100);
    chk("R1 rm", {30'd0, round_mode_o}, 32'd0);
    chk("R1 flush", {31'd0, flush_denorm_o}, 32'd1);
    chk("R1 eit", {31'd0, eit_req_o}, 32'd0);
  endtask

  task automatic t_masked_sticky;
    do_op(E_Z, 1'b0, 1'b0);
    chk("R8 masked dz no trap", {31'd0, eit_seen}, 32'd0);
    chk("R3 dz flag+cause, R2 summary", rd_data_o, 32'h9000_0110);
    do_op(5'b0, 1'b0, 1'b0);
    chk("R5 clean op clears cause, R3 flag sticks", rd_data_o, 32'h9000_0100);
  endtask

  task automatic t_cause_w0c;
    do_op(E_V, 1'b0, 1'b0);
    chk("R5 invalid cause", rd_data_o, 32'h9400_0104);
    sw_write(32'h9400_01FC);
    chk("R6 writing 1 to causes", rd_data_o, 32'h9400_0104);
    sw_write(32'h9400_0100);
    chk("R6 writing 0 clears cause", rd_data_o, 32'h9400_0100);
  endtask

  task automatic t_sw_fields;
    sw_write(32'hFFFF_FFFF);
    chk("R7 all ones write", rd_data_o, 32'hFC00_7D03);
    chk("R12 rm toward -inf", {30'd0, round_mode_o}, 32'd3);
    sw_write(32'h8000_0000);
    chk("R7 summary not writable", rd_data_o, 32'h0000_0000);
    chk("R12 flush off", {31'd0, flush_denorm_o}, 32'd0);
    sw_write(32'h4000_0102);
    chk("R2 inexact excluded from summary", rd_data_o, 32'h4000_0102);
    chk("R12 rm toward +inf", {30'd0, round_mode_o}, 32'd2);
    sw_write(32'h0000_0101);
    chk("R12 rm toward zero", {30'd0, round_mode_o}, 32'd1);
  endtask

  task automatic t_enabled_trap;
    sw_write(32'h0000_1100);
    do_op(E_Z, 1'b0, 1'b0);
    chk("R8 enabled dz traps", {31'd0, eit_seen}, 32'd1);
    chk("R4 no flag on trap", rd_data_o, 32'h0000_1110);
    do_op(E_Z | E_V, 1'b0, 1'b0);
    chk("R4 mixed pair traps", {31'd0, eit_seen}, 32'd1);
    chk("R4 mixed pair flags kept", rd_data_o, 32'h0000_1114);
  endtask

  task automatic t_overflow;
    sw_write(32'h0000_0100);
    do_op(E_O, 1'b0, 1'b0);
    chk("R11 masked ovf no trap", {31'd0, eit_seen}, 32'd0);
    chk("R11 masked ovf adds inexact", rd_data_o, 32'hC800_0148);
    sw_write(32'h0000_0900);
    do_op(E_O, 1'b0, 1'b0);
    chk("R11 enabled ovf traps", {31'd0, eit_seen}, 32'd1);
    chk("R11 enabled ovf no inexact", rd_data_o, 32'h0000_0908);
    sw_write(32'h0000_4100);
    do_op(E_O, 1'b0, 1'b0);
    chk("R11 implied inexact enabled traps", {31'd0, eit_seen}, 32'd1);
    chk("R11 implied inexact cause", rd_data_o, 32'h0000_4148);
  endtask

  task automatic t_unimpl;
    sw_write(32'h0000_0100);
    do_op(5'b0, 1'b1, 1'b0);
    chk("R9 unimpl traps unmasked", {31'd0, eit_seen}, 32'd1);
    chk("R9 unimpl cause", rd_data_o, 32'h0000_0180);
  endtask

  task automatic t_denorm;
    sw_write(32'h0000_0000);
    do_op(5'b0, 1'b0, 1'b1);
    chk("R10 denorm no flush traps", {31'd0, eit_seen}, 32'd1);
    chk("R10 denorm no flush cause", rd_data_o, 32'h0000_0080);
    sw_write(32'h0000_0100);
    do_op(5'b0, 1'b0, 1'b1);
    chk("R10 denorm flushed no trap", {31'd0, eit_seen}, 32'd0);
    chk("R10 denorm flushed quiet", rd_data_o, 32'h0000_0100);
    sw_write(32'h0000_0000);
    do_op(E_U, 1'b0, 1'b0);
    chk("R10 underflow no flush traps", {31'd0, eit_seen}, 32'd1);
    chk("R10 underflow no flush", rd_data_o, 32'h0000_00A0);
    sw_write(32'h0000_0100);
    do_op(E_U, 1'b0, 1'b0);
    chk("R10 underflow flushed masked", rd_data_o, 32'hA000_0120);
  endtask

  task automatic t_no_strobe;
    exc_i = 5'b11111; unimpl_i = 1'b1; denorm_op_i = 1'b1;
    #3 chk("R8 no strobe no trap", {31'd0, eit_req_o}, 32'd0);
    @(negedge clk);
    exc_i = '0; unimpl_i = 1'b0; denorm_op_i = 1'b0;
    chk("R8 no strobe state kept", rd_data_o, 32'hA000_0120);
  endtask

  initial begin
    rst = 1'b1; op_done_i = 1'b0; exc_i = '0; unimpl_i = 1'b0;
    denorm_op_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked_sticky();
    t_cause_w0c();
    t_sw_fields();
    t_enabled_trap();
    t_overflow();
    t_unimpl();
    t_denorm();
    t_no_strobe();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule